// File: doc/BRIEF.md
# Command-Response Buffer Register Controller

This block is the host-facing register set of a TPM 2.0 interface that exchanges commands through a shared buffer. A register bus with per-byte write strobes reaches a small bank of control and status words, and a byte-addressable buffer RAM that sits in the same map. Each 4 KiB window of the address space belongs to one locality. The locality number of an access comes from the address bits at and above bit 12. The controller records which locality owns the interface. It handles the ready and idle requests and keeps the identification and buffer-geometry words that load at reset.

A command starts through a small state machine with three states. READY means no command is in flight. ISSUE lasts one cycle and drives the request pulse to the backend. WAIT means the command is in flight and the block waits for the backend to report completion. The transitions are as follows:
- READY to ISSUE on an accepted start write.
- ISSUE to WAIT unconditionally.
- WAIT to READY when the backend reports completion.

The start bit reads as 1 in ISSUE and in WAIT. While the start bit is set, a cancel write is passed on to the backend as a single pulse. At launch the controller takes the command length from the big-endian size field of the buffer header and limits it to the backend's capacity.

Top module: `crbif_ctrl`

The register map uses offsets within each 4 KiB window:

| Offset | Register | Access |
|---|---|---|
| 0x000 | LOCST | read |
| 0x008 | LOCCTL | write |
| 0x00C | LOCSTS | read |
| 0x030 | IDENT | read |
| 0x040 | CTLREQ | write |
| 0x044 | CTLSTS | read |
| 0x048 | CANCEL | write |
| 0x04C | START | read and write |
| 0x058 | CMDSZ | read |
| 0x05C | CMDADR | read |
| 0x064 | RSPSZ | read |
| 0x068 | RSPADR | read |
| 0x080 + byte | buffer | read and write |

The buffer has BUF_BYTES bytes.

## Requirements
- R1: After reset the registers read as follows. LOCST reads 0x0000FF00 when the backend reports the flag as established. CTLSTS reads 0x2, which means idle. START reads 0. CMDSZ and RSPSZ read BUF_BYTES. CMDADR and RSPADR read BASE+0x80. IDENT reads its fixed fields: type=1 in bits [3:0], version=1 in bits [7:4], transfer size code 3 in bits [12:11], the buffer-interface-supported bit 14 = 1, selector=1 in bits [18:17], and all other bits 0.
- R2: A write of exactly 1 to LOCCTL makes the locality of the write's window the owner. LOCST bit1 then reads 1, LOCST bits [15:8] read that locality and LOCSTS bit0 (granted) reads 1. A write of exactly 2 from any window clears both bits. Any other LOCCTL value has no effect.
- R3: While no locality is assigned, LOCST bits [15:8] read 0xFF, and no start write can be accepted.
- R4: A write of 1 to CTLREQ clears the idle bit, CTLSTS bit1. A write of 2 to CTLREQ sets it.
- R5: A write of exactly 1 to START launches a command only when the start bit is clear and the write comes from the owning locality's window. A launch sets START bit0 and gives exactly one be_req pulse of one cycle. All other start writes are ignored.
- R6: A write of exactly 1 to CANCEL gives one be_cancel pulse only while the start bit is set. Otherwise the write produces no pulse.
- R7: be_done in WAIT clears the start bit. A nonzero be_status sets the fatal bit, CTLSTS bit0, which stays set until reset.
- R8: be_len equals the big-endian 32-bit value in buffer bytes 2..5, limited to BE_CAP. It is valid while be_req is high.
- R9: bus_rdata is registered and appears one cycle after bus_rd. Its value is the aligned word shifted right by 8 times the address bits [1:0].
- R10: LOCST bit0 reads as the inverse of be_established.
- R11: A read of an undefined offset returns 0. Writes to read-only registers are ignored.
- R12: Buffer writes update only the byte lanes whose bus_be bit is set. Buffer reads return the stored bytes in little-endian order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:12] select the locality |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Write byte enables |
| bus_rdata | output | 32 | Registered read data |
| be_req | output | 1 | One-cycle command request to the backend |
| be_cancel | output | 1 | One-cycle cancel request to the backend |
| be_len | output | 32 | Command length sent with be_req |
| be_done | input | 1 | Backend completion |
| be_status | input | ST_W | Completion status; nonzero means failure |
| be_established | input | 1 | Establishment flag from the backend |

## Verification
The bench targets the following corner cases:
- A start write from a window that does not own the interface. A design that skips the locality comparison would issue a request that should not occur.
- A second start write while a command is in flight. A design that ignores the start bit would send a duplicate request.
- A cancel write with no command in flight. A design that ignores the start bit here would send a spurious cancel pulse.
- A header size larger than the backend capacity. A design without the limit would overrun the backend.
- A failing completion. A design that mishandles it would not set the fatal bit, or would let the next good completion clear it.
- Sub-word reads at each byte offset, and random masked buffer writes. These expose lane or shift errors.

// File: rtl/crbif_pkg.sv
package crbif_pkg;

    localparam logic [11:0] OFF_LOC_STATE = 12'h000;
    localparam logic [11:0] OFF_LOC_CTRL  = 12'h008;
    localparam logic [11:0] OFF_LOC_STS   = 12'h00C;
    localparam logic [11:0] OFF_IDENT     = 12'h030;
    localparam logic [11:0] OFF_CTL_REQ   = 12'h040;
    localparam logic [11:0] OFF_CTL_STS   = 12'h044;
    localparam logic [11:0] OFF_CANCEL    = 12'h048;
    localparam logic [11:0] OFF_START     = 12'h04C;
    localparam logic [11:0] OFF_CMD_SZ    = 12'h058;
    localparam logic [11:0] OFF_CMD_ADR   = 12'h05C;
    localparam logic [11:0] OFF_RSP_SZ    = 12'h064;
    localparam logic [11:0] OFF_RSP_ADR   = 12'h068;
    localparam logic [11:0] OFF_BUF       = 12'h080;

    localparam logic [7:0] NO_OWNER = 8'hFF;

    // identification fields
    localparam logic [31:0] IDENT_VALUE = (32'd1 << 0)   // interface type
                                        | (32'd1 << 4)   // version
                                        | (32'd3 << 11)  // transfer size code
                                        | (32'd1 << 14)  // buffer interface supported
                                        | (32'd1 << 17); // selector

    typedef enum logic [1:0] {
        CS_READY = 2'd0,
        CS_ISSUE = 2'd1,
        CS_WAIT  = 2'd2
    } cmd_state_t;

endpackage

// File: rtl/crbif_buf.sv
module crbif_buf #(
    parameter int BUF_BYTES = 128,
    localparam int WORDS  = BUF_BYTES / 4,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [WIDX_W-1:0] widx,
    input  logic [3:0]        wbe,
    input  logic [31:0]       wdata,
    input  logic [WIDX_W-1:0] ridx,
    output logic [31:0]       rword,
    output logic [31:0]       hdr_size
);
    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk) begin
        for (int l = 0; l < 4; l++) begin
            if (we && wbe[l])
                mem[{widx, 2'(l)}] <= wdata[8*l +: 8];
        end
    end

    always_comb begin
        rword    = {mem[{ridx, 2'd3}], mem[{ridx, 2'd2}], mem[{ridx, 2'd1}], mem[{ridx, 2'd0}]};
        hdr_size = {mem[2], mem[3], mem[4], mem[5]};
    end
endmodule

// File: rtl/crbif_loc.sv
module crbif_loc #(
    parameter int LOC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [31:0]      ctl_val,
    input  logic [LOC_W-1:0] wr_loc,
    output logic             assigned,
    output logic [LOC_W-1:0] active,
    output logic             granted
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assigned <= 1'b0;
            active   <= '0;
            granted  <= 1'b0;
        end else if (ctl_we) begin
            unique case (ctl_val)
                32'd1: begin
                    assigned <= 1'b1;
                    active   <= wr_loc;
                    granted  <= 1'b1;
                end
                32'd2: begin
                    assigned <= 1'b0;
                    granted  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R2
    req_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_val == 32'd1) |=> (assigned && granted && active == $past(wr_loc)));

    // R2
    rel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_val == 32'd2) |=> (!assigned && !granted));
endmodule

// File: rtl/crbif_cmd_fsm.sv
module crbif_cmd_fsm
    import crbif_pkg::*;
#(
    parameter int ST_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_we,
    input  logic [31:0]     start_val,
    input  logic            cancel_we,
    input  logic [31:0]     cancel_val,
    input  logic            loc_match,
    input  logic            be_done,
    input  logic [ST_W-1:0] be_status,
    output logic            launch,
    output logic            busy,
    output logic            be_req,
    output logic            be_cancel,
    output logic            fatal
);
    cmd_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        launch   = 1'b0;
        unique case (state)
            CS_READY: if (start_we && start_val == 32'd1 && loc_match) begin
                state_nx = CS_ISSUE;
                launch   = 1'b1;
            end
            CS_ISSUE: state_nx = CS_WAIT;
            CS_WAIT:  if (be_done) state_nx = CS_READY;
            default:  state_nx = CS_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CS_READY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_cancel <= 1'b0;
            fatal     <= 1'b0;
        end else begin
            be_cancel <= cancel_we && cancel_val == 32'd1 && state != CS_READY;
            if (state == CS_WAIT && be_done && be_status != '0)
                fatal <= 1'b1;
        end
    end

    always_comb begin
        busy   = (state != CS_READY);
        be_req = (state == CS_ISSUE);
    end

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |=> !be_req);

    // R5
    req_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> $past(start_we && loc_match));

    // R6
    cancel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_cancel |-> $past(busy));

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_WAIT && be_done) |=> !busy);

    // R7
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);
endmodule

// File: rtl/crbif_ctrl.sv
module crbif_ctrl
    import crbif_pkg::*;
#(
    parameter int          ADDR_W    = 15,
    parameter int          BUF_BYTES = 128,
    parameter int          BE_CAP    = 96,
    parameter logic [31:0] BASE      = 32'hFED4_0000,
    parameter int          ST_W      = 8,
    localparam int LOC_W  = ADDR_W - 12,
    localparam int WIDX_W = $clog2(BUF_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    output logic              be_req,
    output logic              be_cancel,
    output logic [31:0]       be_len,
    input  logic              be_done,
    input  logic [ST_W-1:0]   be_status,
    input  logic              be_established
);
    logic [11:0]       off;
    logic [11:0]       word_off;
    logic [LOC_W-1:0]  wloc;
    logic              in_buf;
    logic [WIDX_W-1:0] bidx;
    logic [31:0]       wval;
    logic              reg_we;
    logic              assigned, granted, busy, fatal, launch, loc_match;
    logic [LOC_W-1:0]  active;
    logic [7:0]        owner_rd;
    logic              idle;
    logic [31:0]       buf_word, hdr_size, word, len_clamp;

    always_comb begin
        off      = bus_addr[11:0];
        word_off = {off[11:2], 2'b00};
        wloc     = bus_addr[ADDR_W-1:12];
        in_buf   = (32'(word_off) >= 32'(OFF_BUF)) && (32'(word_off) < 32'(OFF_BUF) + 32'(BUF_BYTES));
        bidx     = WIDX_W'((32'(word_off) - 32'(OFF_BUF)) >> 2);
        for (int l = 0; l < 4; l++)
            wval[8*l +: 8] = bus_be[l] ? bus_wdata[8*l +: 8] : 8'h00;
        reg_we    = bus_wr && !in_buf;
        loc_match = assigned && (active == wloc);
        owner_rd  = assigned ? 8'(active) : NO_OWNER;
        len_clamp = (hdr_size > 32'(BE_CAP)) ? 32'(BE_CAP) : hdr_size;
    end

    crbif_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk      (clk),
        .we       (bus_wr && in_buf),
        .widx     (bidx),
        .wbe      (bus_be),
        .wdata    (bus_wdata),
        .ridx     (bidx),
        .rword    (buf_word),
        .hdr_size (hdr_size)
    );

    crbif_loc #(.LOC_W(LOC_W)) u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (reg_we && word_off == OFF_LOC_CTRL),
        .ctl_val  (wval),
        .wr_loc   (wloc),
        .assigned (assigned),
        .active   (active),
        .granted  (granted)
    );

    crbif_cmd_fsm #(.ST_W(ST_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_we   (reg_we && word_off == OFF_START),
        .start_val  (wval),
        .cancel_we  (reg_we && word_off == OFF_CANCEL),
        .cancel_val (wval),
        .loc_match  (loc_match),
        .be_done    (be_done),
        .be_status  (be_status),
        .launch     (launch),
        .busy       (busy),
        .be_req     (be_req),
        .be_cancel  (be_cancel),
        .fatal      (fatal)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle   <= 1'b1;
            be_len <= '0;
        end else begin
            if (reg_we && word_off == OFF_CTL_REQ) begin
                if (wval == 32'd1)      idle <= 1'b0;
                else if (wval == 32'd2) idle <= 1'b1;
            end
            if (launch) be_len <= len_clamp;
        end
    end

    always_comb begin
        unique case (word_off)
            OFF_LOC_STATE: word = {16'h0000, owner_rd, 6'b0, assigned, ~be_established};
            OFF_LOC_STS:   word = {31'b0, granted};
            OFF_IDENT:     word = IDENT_VALUE;
            OFF_CTL_STS:   word = {30'b0, idle, fatal};
            OFF_START:     word = {31'b0, busy};
            OFF_CMD_SZ,
            OFF_RSP_SZ:    word = 32'(BUF_BYTES);
            OFF_CMD_ADR,
            OFF_RSP_ADR:   word = BASE + 32'(OFF_BUF);
            default:       word = in_buf ? buf_word : 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= word >> {bus_addr[1:0], 3'b000};
    end

    // R8
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (be_len <= 32'(BE_CAP)));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/sim_crbif_ctrl.sv
`timescale 1ns/1ps
module sim_crbif_ctrl;
    localparam int          ADDR_W = 15;
    localparam int          BUFB   = 128;
    localparam int          CAP    = 96;
    localparam logic [31:0] BASEA  = 32'hFED4_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        be_req, be_cancel;
    logic [31:0] be_len;
    logic        be_done = 1'b0;
    logic [7:0]  be_status = '0;
    logic        be_established = 1'b1;

    int checks = 0, errors = 0;
    int req_cnt = 0, cancel_cnt = 0;
    logic [31:0] last_len = '0;
    int cycles = 0;
    logic [7:0] model [BUFB];

    always #2.5 clk = ~clk;

    crbif_ctrl #(.ADDR_W(ADDR_W), .BUF_BYTES(BUFB), .BE_CAP(CAP), .BASE(BASEA)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .be_req(be_req), .be_cancel(be_cancel), .be_len(be_len),
        .be_done(be_done), .be_status(be_status), .be_established(be_established));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (be_req) begin req_cnt <= req_cnt + 1; last_len <= be_len; end
        if (be_cancel) cancel_cnt <= cancel_cnt + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] exp_ident();
        return 32'd1 | (32'd1 << 4) | (32'd3 << 11) | (32'd1 << 14) | (32'd1 << 17);
    endfunction

    function automatic logic [31:0] exp_len(input logic [31:0] sz);
        return (sz > CAP) ? CAP : sz;
    endfunction

    function automatic logic [31:0] exp_locst(input logic asg, input logic [7:0] own, input logic est);
        return {16'h0, asg ? own : 8'hFF, 6'b0, asg, ~est};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int loc, input int offs, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'((loc << 12) + offs); bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input int loc, input int offs, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'((loc << 12) + offs);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_hdr(input logic [31:0] sz);
        wr(0, 'h80, {sz[23:16], sz[31:24], 8'h01, 8'h80}, 4'hF);
        wr(0, 'h84, {16'h0000, sz[7:0], sz[15:8]}, 4'hF);
    endtask

    task automatic finish_cmd(input logic [7:0] st);
        @(negedge clk);
        be_done = 1'b1; be_status = st;
        @(negedge clk);
        be_done = 1'b0; be_status = '0;
    endtask

    initial begin
        logic [31:0] v;
        int r0, c0;
        void'($urandom(32'd4242));
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(1);

        // R1 reset values
        rd(0, 'h000, v); chk("R1 locst", v, exp_locst(0, 0, 1));
        rd(0, 'h044, v); chk("R1 ctlsts", v, 32'h2);
        rd(0, 'h04C, v); chk("R1 start", v, 32'h0);
        rd(0, 'h030, v); chk("R1 ident", v, exp_ident());
        rd(0, 'h058, v); chk("R1 cmdsz", v, BUFB);
        rd(0, 'h05C, v); chk("R1 cmdadr", v, BASEA + 32'h80);
        rd(0, 'h064, v); chk("R1 rspsz", v, BUFB);
        rd(0, 'h068, v); chk("R1 rspadr", v, BASEA + 32'h80);

        // R10 establishment inverse
        be_established = 1'b0;
        rd(0, 'h000, v); chk("R10 est", v, exp_locst(0, 0, 0));
        be_established = 1'b1;

        // R4 ready/idle
        wr(0, 'h040, 32'h1, 4'hF); rd(0, 'h044, v); chk("R4 ready", v, 32'h0);
        wr(0, 'h040, 32'h2, 4'hF); rd(0, 'h044, v); chk("R4 idle", v, 32'h2);

        // R3 start with no owner
        set_hdr(32'd10);
        r0 = req_cnt;
        wr(0, 'h04C, 32'h1, 4'hF); idle_cycles(2);
        rd(0, 'h04C, v); chk("R3 start no owner", v, 32'h0);
        chk("R3 no req", 32'(req_cnt), 32'(r0));

        // R6 cancel while idle
        c0 = cancel_cnt;
        wr(0, 'h048, 32'h1, 4'hF); idle_cycles(2);
        chk("R6 cancel idle", 32'(cancel_cnt), 32'(c0));

        // R2 request access from locality 0; odd value ignored
        wr(0, 'h008, 32'h3, 4'hF); rd(0, 'h000, v); chk("R2 odd ignored", v, exp_locst(0, 0, 1));
        wr(0, 'h008, 32'h1, 4'hF);
        rd(0, 'h000, v); chk("R2 owner0", v, exp_locst(1, 0, 1));
        rd(0, 'h00C, v); chk("R2 granted", v, 32'h1);

        // R5 start from a foreign window
        wr(1, 'h04C, 32'h1, 4'hF); idle_cycles(2);
        chk("R5 foreign", 32'(req_cnt), 32'(r0));
        // R5 value other than 1
        wr(0, 'h04C, 32'h3, 4'hF); idle_cycles(2);
        chk("R5 value3", 32'(req_cnt), 32'(r0));
        // R5 launch, R8 length
        wr(0, 'h04C, 32'h1, 4'hF); idle_cycles(2);
        chk("R5 launch", 32'(req_cnt), 32'(r0 + 1));
        chk("R8 len", last_len, exp_len(32'd10));
        rd(0, 'h04C, v); chk("R5 startbit", v, 32'h1);
        // R5 second start while busy
        wr(0, 'h04C, 32'h1, 4'hF); idle_cycles(2);
        chk("R5 busy restart", 32'(req_cnt), 32'(r0 + 1));
        // R6 cancel while busy
        wr(0, 'h048, 32'h1, 4'hF); idle_cycles(2);
        chk("R6 cancel busy", 32'(cancel_cnt), 32'(c0 + 1));
        // R7 good completion
        finish_cmd(8'h00);
        rd(0, 'h04C, v); chk("R7 start clear", v, 32'h0);
        rd(0, 'h044, v); chk("R7 no fatal", v, 32'h2);

        // R2 owner moves to locality 1; R8 clamp; R7 failing completion
        wr(1, 'h008, 32'h1, 4'hF);
        rd(1, 'h000, v); chk("R2 owner1", v, exp_locst(1, 1, 1));
        set_hdr(32'd200);
        wr(0, 'h04C, 32'h1, 4'hF); idle_cycles(2);
        chk("R5 old owner", 32'(req_cnt), 32'(r0 + 1));
        wr(1, 'h04C, 32'h1, 4'hF); idle_cycles(2);
        chk("R5 launch loc1", 32'(req_cnt), 32'(r0 + 2));
        chk("R8 clamp", last_len, exp_len(32'd200));
        finish_cmd(8'h05);
        rd(0, 'h044, v); chk("R7 fatal", v, 32'h3);
        wr(1, 'h04C, 32'h1, 4'hF); idle_cycles(2);
        finish_cmd(8'h00);
        rd(0, 'h044, v); chk("R7 fatal sticky", v, 32'h3);

        // R9 sub-word reads
        for (int b = 0; b < 4; b++) begin
            rd(0, 'h030 + b, v); chk("R9 shift", v, exp_ident() >> (8 * b));
        end

        // R11 undefined and read-only
        rd(0, 'h010, v); chk("R11 undef", v, 32'h0);
        rd(0, 'h048, v); chk("R11 cancel reads 0", v, 32'h0);
        wr(0, 'h030, 32'hFFFF_FFFF, 4'hF);
        rd(0, 'h030, v); chk("R11 ro ident", v, exp_ident());
        wr(0, 'h058, 32'h0, 4'hF);
        rd(0, 'h058, v); chk("R11 ro size", v, BUFB);

        // R2 relinquish
        wr(2, 'h008, 32'h2, 4'hF);
        rd(0, 'h000, v); chk("R2 relinquish", v, exp_locst(0, 0, 1));
        rd(0, 'h00C, v); chk("R2 not granted", v, 32'h0);

        // R12 random byte-lane buffer traffic
        for (int w = 0; w < BUFB / 4; w++) begin
            wr(0, 'h80 + 4 * w, 32'h0, 4'hF);
            for (int l = 0; l < 4; l++) model[4 * w + l] = 8'h00;
        end
        for (int k = 0; k < 60; k++) begin
            int w;
            logic [3:0] be;
            logic [31:0] d;
            w  = int'($urandom_range(BUFB / 4 - 1, 0));
            be = 4'($urandom_range(15, 1));
            d  = $urandom;
            wr(k % 8, 'h80 + 4 * w, d, be);
            for (int l = 0; l < 4; l++) if (be[l]) model[4 * w + l] = d[8 * l +: 8];
        end
        for (int w = 0; w < BUFB / 4; w++) begin
            rd(0, 'h80 + 4 * w, v);
            chk("R12 buffer", v, {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]});
        end
        // R9 random sub-word buffer reads
        for (int k = 0; k < 12; k++) begin
            int a;
            logic [31:0] wv;
            a  = int'($urandom_range(BUFB - 1, 0));
            wv = {model[(a & ~3) + 3], model[(a & ~3) + 2], model[(a & ~3) + 1], model[a & ~3]};
            rd(0, 'h80 + a, v); chk("R9 buf shift", v, wv >> (8 * (a & 3)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule